// File: doc/BRIEF.md
# Core Local Reset and Debug Halt Sequencer

This block is the small control machine that sits beside a processor pipeline and decides when instruction issue must stop. It handles two requests that are separate from the chip-wide reset. The first is a core-local reset request. It lets the instructions already in flight finish. It then parks the core in a reset state, where it acknowledges periodically and issues dummy reads of the reset address that are thrown away. The second is a debug halt request. It stops the core as a breakpoint would: it strobes a redirect to the break address and holds a debug acknowledge until the debugger releases the core.

The pipeline, the fetch unit and the debugger transport are outside the block. They appear only as a pipeline-empty level, a release pulse, and the strobes this block drives. A global active-low reset overrides everything and stalls issue at once, with no drain.

Top module: `core_halt_seq`

## Requirements
- R1: While `rst_n` is low, `issue_stall` is 1 and every strobe and `dbg_ack` are 0. One cycle after `rst_n` rises, `issue_stall` is 0.
- R2: A `lrst_req` sampled high while running raises `issue_stall` in the next cycle. No `rst_taken` appears while `pipe_empty` stays low.
- R3: Once draining, the clock edge that samples `pipe_empty` high enters the reset state. `rst_taken` is high for exactly the one cycle after that edge.
- R4: While `lrst_req` stays high in the reset state, `rst_taken` and `rst_vec_read` repeat exactly every `HOLD_PERIOD` cycles, counted from the entry pulse. `rst_vec_read` is high in exactly the cycles where `rst_taken` is.
- R5: `issue_stall` stays high for as long as `lrst_req` is held. The edge that samples `lrst_req` low in the reset state gives a one-cycle `restart_fetch` strobe, and `issue_stall` is 0 in that same cycle.
- R6: A `dbg_req` sampled high while running gives a one-cycle `brk_redirect` and raises `dbg_ack` and `issue_stall` in the next cycle. When `dbg_req` and `lrst_req` arrive in the same cycle, the debug halt wins.
- R7: A `dbg_req` while paused causes no further `brk_redirect`, and `dbg_ack` stays high.
- R8: A `lrst_req` while paused gives no `rst_taken`, and the core stays paused.
- R9: A `dbg_release` pulse while paused drops `dbg_ack` in the next cycle. If `lrst_req` is high at that edge, the drain of R2/R3 starts, with `issue_stall` kept high. Otherwise `issue_stall` drops in that cycle.
- R10: A `dbg_req` while draining or held in reset is ignored: no `brk_redirect` and no `dbg_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, asynchronous, active low |
| lrst_req | input | 1 | Core-local reset request, level |
| dbg_req | input | 1 | Debug halt request, level |
| pipe_empty | input | 1 | No instruction remains in flight |
| dbg_release | input | 1 | Debugger gives up control (step or resume), one-cycle pulse |
| issue_stall | output | 1 | Blocks instruction issue |
| rst_taken | output | 1 | Reset-state acknowledge pulse |
| rst_vec_read | output | 1 | Dummy read of the reset address, data discarded |
| restart_fetch | output | 1 | Fetch restarts at the reset address |
| brk_redirect | output | 1 | Fetch redirect to the break address |
| dbg_ack | output | 1 | Core is paused under debugger control |

## Verification
The local reset is driven with the pipeline kept busy for several cycles, which separates a correct drain from an early acknowledge. It is then held long enough for three re-pulses, which exposes an off-by-one in the period counter. A debug halt is followed by repeated halt requests and by a reset request while paused. A release with the reset still requested, and another without it, show whether the pause masks the reset and then honours it. Simultaneous halt and reset requests, and halt requests during the reset hold, fix the priority between the two paths.

// File: rtl/core_halt_pkg.sv
package core_halt_pkg;

   typedef enum logic [1:0] {
      HS_RUN   = 2'd0,
      HS_DRAIN = 2'd1,
      HS_HOLD  = 2'd2,
      HS_PAUSE = 2'd3
   } hs_state_e;

endpackage

// File: rtl/hs_period_timer.sv
module hs_period_timer #(
   parameter int PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   localparam int  CNT_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam bit  IS_POW2 = (PERIOD & (PERIOD - 1)) == 0;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == LAST);

   generate
      if (IS_POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (restart) cnt_q <= '0;
            else if (run)     cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_compare
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt_q <= '0;
            else if (restart) cnt_q <= '0;
            else if (run)     cnt_q <= tick ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
   import core_halt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lrst_req,
   input  logic      dbg_req,
   input  logic      pipe_empty,
   input  logic      dbg_release,
   output hs_state_e state_q,
   output hs_state_e state_d,
   output logic      enter_hold,
   output logic      leave_hold,
   output logic      enter_pause
);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         HS_RUN: begin
            if (dbg_req)       state_d = HS_PAUSE;
            else if (lrst_req) state_d = HS_DRAIN;
         end
         HS_DRAIN: begin
            if (pipe_empty)    state_d = HS_HOLD;
         end
         HS_HOLD: begin
            if (!lrst_req)     state_d = HS_RUN;
         end
         HS_PAUSE: begin
            if (dbg_release)   state_d = lrst_req ? HS_DRAIN : HS_RUN;
         end
         default:              state_d = HS_RUN;
      endcase
   end

   assign enter_hold  = (state_q == HS_DRAIN) && (state_d == HS_HOLD);
   assign leave_hold  = (state_q == HS_HOLD)  && (state_d == HS_RUN);
   assign enter_pause = (state_q == HS_RUN)   && (state_d == HS_PAUSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= HS_RUN;
      else        state_q <= state_d;
   end

endmodule

// File: rtl/core_halt_seq.sv
module core_halt_seq
   import core_halt_pkg::*;
#(
   parameter int HOLD_PERIOD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lrst_req,
   input  logic dbg_req,
   input  logic pipe_empty,
   input  logic dbg_release,
   output logic issue_stall,
   output logic rst_taken,
   output logic rst_vec_read,
   output logic restart_fetch,
   output logic brk_redirect,
   output logic dbg_ack
);

   generate
      if (HOLD_PERIOD < 2) begin : g_bad_period
         initial $fatal(1, "core_halt_seq: HOLD_PERIOD must be at least 2");
      end
   endgenerate

   hs_state_e state_q;
   hs_state_e state_d;
   logic      enter_hold;
   logic      leave_hold;
   logic      enter_pause;
   logic      hold_tick;
   logic      repulse;

   hs_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .lrst_req    (lrst_req),
      .dbg_req     (dbg_req),
      .pipe_empty  (pipe_empty),
      .dbg_release (dbg_release),
      .state_q     (state_q),
      .state_d     (state_d),
      .enter_hold  (enter_hold),
      .leave_hold  (leave_hold),
      .enter_pause (enter_pause)
   );

   hs_period_timer #(.PERIOD(HOLD_PERIOD)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (enter_hold),
      .run     (state_q == HS_HOLD),
      .tick    (hold_tick)
   );

   // a re-pulse only while the request is still held; an exit on the same edge wins
   assign repulse = hold_tick && lrst_req;

   logic taken_q, restart_q, redirect_q, ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q    <= 1'b0;
         restart_q  <= 1'b0;
         redirect_q <= 1'b0;
         ack_q      <= 1'b0;
      end else begin
         taken_q    <= enter_hold | repulse;
         restart_q  <= leave_hold;
         redirect_q <= enter_pause;
         ack_q      <= (state_d == HS_PAUSE);
      end
   end

   assign issue_stall   = !rst_n || (state_q != HS_RUN);
   assign rst_taken     = taken_q;
   assign rst_vec_read  = taken_q;
   assign restart_fetch = restart_q;
   assign brk_redirect  = redirect_q;
   assign dbg_ack       = ack_q;

endmodule

// File: rtl/core_halt_seq_chk.sv
module core_halt_seq_chk #(
   parameter int HOLD_PERIOD = 16
) (
   input logic clk,
   input logic rst_n,
   input logic lrst_req,
   input logic dbg_req,
   input logic pipe_empty,
   input logic dbg_release,
   input logic issue_stall,
   input logic rst_taken,
   input logic rst_vec_read,
   input logic restart_fetch,
   input logic brk_redirect,
   input logic dbg_ack
);

   int   gap_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= 0;
         armed_q <= 1'b0;
      end else if (rst_taken) begin
         gap_q   <= 0;
         armed_q <= 1'b1;
      end else if (!issue_stall) begin
         armed_q <= 1'b0;
      end else begin
         gap_q   <= gap_q + 1;
      end
   end

   // R3: acknowledge lasts one cycle and only while issue is stalled
   a_r3_taken_single: assert property (@(posedge clk) disable iff (!rst_n)
      rst_taken |=> !rst_taken);
   a_r3_taken_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      rst_taken |-> issue_stall);

   // R4: re-pulse spacing while held
   a_r4_exact_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_taken && armed_q) |-> (gap_q == HOLD_PERIOD - 1));

   // R5: restart comes with issue released, right after a stalled cycle
   a_r5_restart_release: assert property (@(posedge clk) disable iff (!rst_n)
      restart_fetch |-> (!issue_stall && $past(issue_stall)));

   // R6: redirect marks the first acknowledged cycle
   a_r6_redirect_ack: assert property (@(posedge clk) disable iff (!rst_n)
      brk_redirect |-> (dbg_ack && issue_stall && !$past(dbg_ack)));

   // R7: acknowledge holds until released
   a_r7_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_ack && !dbg_release) |=> dbg_ack);

   // R8: no reset acknowledge while paused
   a_r8_no_taken_paused: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_ack |-> !rst_taken);

   // R9: release drops acknowledge on the next cycle
   a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_ack && dbg_release) |=> !dbg_ack);

endmodule

bind core_halt_seq core_halt_seq_chk #(.HOLD_PERIOD(HOLD_PERIOD)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lrst_req      (lrst_req),
   .dbg_req       (dbg_req),
   .pipe_empty    (pipe_empty),
   .dbg_release   (dbg_release),
   .issue_stall   (issue_stall),
   .rst_taken     (rst_taken),
   .rst_vec_read  (rst_vec_read),
   .restart_fetch (restart_fetch),
   .brk_redirect  (brk_redirect),
   .dbg_ack       (dbg_ack)
);

// File: tb/sim_core_halt_seq.sv
`timescale 1ns/1ps
module sim_core_halt_seq;
   localparam int P = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic lrst_req = 1'b0, dbg_req = 1'b0, pipe_empty = 1'b0, dbg_release = 1'b0;
   logic issue_stall, rst_taken, rst_vec_read, restart_fetch, brk_redirect, dbg_ack;

   core_halt_seq #(.HOLD_PERIOD(P)) u0 (
      .clk(clk), .rst_n(rst_n), .lrst_req(lrst_req), .dbg_req(dbg_req),
      .pipe_empty(pipe_empty), .dbg_release(dbg_release),
      .issue_stall(issue_stall), .rst_taken(rst_taken), .rst_vec_read(rst_vec_read),
      .restart_fetch(restart_fetch), .brk_redirect(brk_redirect), .dbg_ack(dbg_ack)
   );

   always #2 clk = ~clk;   // 250 MHz

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int exp_taken[$];
   int exp_redir[$];
   int exp_restart[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic pop_cmp(ref int q[$], input string tag);
      if (q.size() == 0) chk(1'b0, tag, cyc, -1);
      else begin
         int e = q.pop_front();
         chk(e == cyc, tag, cyc, e);
      end
   endtask

   // monitor: compare each produced strobe against the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_taken)     pop_cmp(exp_taken,   "R3/R4 rst_taken");
         if (brk_redirect)  pop_cmp(exp_redir,   "R6/R7/R10 brk_redirect");
         if (restart_fetch) pop_cmp(exp_restart, "R5 restart_fetch");
         if (rst_taken || rst_vec_read)
            chk(rst_vec_read == rst_taken, "R4 rst_vec_read", rst_vec_read, rst_taken);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      int base;
      #1 rst_n = 1'b0;
      step(3);
      // R1 reset state
      chk(issue_stall == 1'b1, "R1 stall in reset", issue_stall, 1);
      chk({rst_taken, restart_fetch, brk_redirect, dbg_ack} == 4'b0, "R1 outputs in reset",
          {rst_taken, restart_fetch, brk_redirect, dbg_ack}, 0);
      rst_n = 1'b1;
      step(1);
      chk(issue_stall == 1'b0, "R1 stall after reset", issue_stall, 0);

      // local reset with a busy pipeline
      lrst_req = 1'b1;
      pipe_empty = 1'b0;
      step(1);
      chk(issue_stall == 1'b1, "R2 stall on request", issue_stall, 1);
      for (int i = 0; i < 4; i++) begin
         step(1);
         chk(rst_taken == 1'b0, "R2 no taken while busy", rst_taken, 0);
      end
      pipe_empty = 1'b1;
      base = cyc + 1;
      for (int k = 0; k < 4; k++) exp_taken.push_back(base + k * P);
      step(1);
      pipe_empty = 1'b0;
      chk(rst_taken == 1'b1, "R3 taken after drain", rst_taken, 1);
      // R10: halt request during hold is ignored
      step(3);
      dbg_req = 1'b1;
      step(3);
      dbg_req = 1'b0;
      chk(dbg_ack == 1'b0, "R10 no ack in hold", dbg_ack, 0);
      while (cyc < base + 3 * P + 2) step(1);
      chk(issue_stall == 1'b1, "R5 stall while held", issue_stall, 1);
      lrst_req = 1'b0;
      exp_restart.push_back(cyc + 1);
      step(1);
      chk(issue_stall == 1'b0, "R5 stall released", issue_stall, 0);
      step(2);

      // debug halt
      dbg_req = 1'b1;
      exp_redir.push_back(cyc + 1);
      step(1);
      chk(dbg_ack == 1'b1, "R6 ack raised", dbg_ack, 1);
      chk(issue_stall == 1'b1, "R6 stall in pause", issue_stall, 1);
      step(3);
      chk(dbg_ack == 1'b1, "R7 ack held under repeat request", dbg_ack, 1);
      dbg_req = 1'b0;
      lrst_req = 1'b1;
      pipe_empty = 1'b1;
      step(5);
      chk(dbg_ack == 1'b1, "R8 still paused with reset request", dbg_ack, 1);
      pipe_empty = 1'b0;
      dbg_release = 1'b1;
      step(1);
      dbg_release = 1'b0;
      chk(dbg_ack == 1'b0, "R9 ack dropped", dbg_ack, 0);
      chk(issue_stall == 1'b1, "R9 drain after release", issue_stall, 1);
      step(2);
      pipe_empty = 1'b1;
      exp_taken.push_back(cyc + 1);
      step(1);
      pipe_empty = 1'b0;
      lrst_req = 1'b0;
      exp_restart.push_back(cyc + 1);
      step(3);

      // simultaneous requests: debug wins, then release without reset
      dbg_req = 1'b1;
      lrst_req = 1'b1;
      exp_redir.push_back(cyc + 1);
      step(1);
      dbg_req = 1'b0;
      lrst_req = 1'b0;
      chk(dbg_ack == 1'b1, "R6 debug wins over reset", dbg_ack, 1);
      step(2);
      dbg_release = 1'b1;
      step(1);
      dbg_release = 1'b0;
      chk(dbg_ack == 1'b0, "R9 ack dropped on resume", dbg_ack, 0);
      chk(issue_stall == 1'b0, "R9 resume without reset", issue_stall, 0);
      step(P + 4);

      chk(exp_taken.size() == 0, "R4 missing rst_taken", exp_taken.size(), 0);
      chk(exp_redir.size() == 0, "R6 missing brk_redirect", exp_redir.size(), 0);
      chk(exp_restart.size() == 0, "R5 missing restart_fetch", exp_restart.size(), 0);
      finish_run();
   end

   initial begin
      wait (cyc > 20000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_run();
   end
endmodule